// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a signed 64-bit running sum in two 32-bit halves, `acc_hi` above `acc_lo`. On each accepted operation it multiplies two signed operands and adds the product into the sum. In long mode the full 32-bit operands are multiplied. In word mode only the low 16 bits of each operand are used, taken as signed values.

A per-operation saturation bit controls what happens on overflow, and each mode handles it in its own way. Long mode keeps the result within a 48-bit signed range by constraining the high word. Word mode clips the result to a 32-bit signed value held in the low word, and sets the high word to 1 to show that clipping took place. With saturation off, the 64-bit sum wraps around.

Software-visible state changes only through three paths: a synchronous clear, separate direct loads of either half, and the operation path. The results appear one clock after the request.

Top module: `sat_mac`

## Requirements
- R1: While `rst_n` is low, and in the cycle after reset, both `acc_hi` and `acc_lo` read zero.
- R2: In long mode (`op_mode`=0), `{acc_hi,acc_lo}` gains the full signed 64-bit product of `op_a` and `op_b`.
- R3: In word mode (`op_mode`=1), the product is taken from the sign-extended bits 15:0 of each operand only. Bits 31:16 of the operands have no effect.
- R4: With `sat_en`=0, the 64-bit sum is written back modulo 2^64 in both modes.
- R5: In long mode with `sat_en`=1 and a negative 64-bit sum, bits 31:16 of `acc_hi` are forced to one. With a non-negative sum, `acc_hi` is the sum's high word ANDed with 0x00007FFF. `acc_lo` is the sum's low word in both cases.
- R6: In word mode with `sat_en`=1, a sum above 2^31-1 gives `acc_lo`=0x7FFFFFFF, and a sum below -2^31 gives `acc_lo`=0x80000000. In both cases `acc_hi` is 1.
- R7: In word mode with `sat_en`=1 and a sum inside the signed 32-bit range, the unclipped 64-bit sum is written.
- R8: `clr` zeroes both halves and overrides any load or operation in the same cycle.
- R9: `ld_hi` writes `ld_data` into `acc_hi`, and `ld_lo` writes it into `acc_lo`. A half whose strobe is low keeps its value.
- R10: When either load strobe is high (and `clr` is low), an operation requested in the same cycle is discarded.
- R11: With no strobe asserted, both halves hold their values.
- R12: Every update is visible on the outputs exactly one clock edge after the strobe that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Accept a multiply-accumulate this cycle |
| op_mode | input | 1 | 0 = long (32x32), 1 = word (16x16) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sat_en | input | 1 | Apply the mode's saturation rule |
| clr | input | 1 | Synchronous zeroing of both halves |
| ld_hi | input | 1 | Load `ld_data` into the high half |
| ld_lo | input | 1 | Load `ld_data` into the low half |
| ld_data | input | 32 | Data for direct loads |
| acc_hi | output | 32 | Upper accumulator word |
| acc_lo | output | 32 | Lower accumulator word |

## Verification
The bench runs long-mode products of mixed signs from zero, and word-mode operands whose upper bits carry unrelated data. These two patterns separate a correct operand slice from one that uses the full width. A sum loaded just below 2^63 and then incremented tells wraparound apart from any clipping. Extreme positive and negative long products with saturation on show whether the high word is masked or filled with ones. Word-mode additions that cross +2^31-1 and -2^31, together with one that stays in range, show whether clipping fires and whether it sets the indicator only when it should. Finally, collisions of clear, load and operation strobes in one cycle expose the priority order.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic {
      MODE_LONG = 1'b0,
      MODE_WORD = 1'b1
   } mac_mode_e;
endpackage

// File: rtl/mac_prod.sv
module mac_prod
   import mac_pkg::*;
#(
   parameter int W  = 32,
   parameter int HW = 16
) (
   input  mac_mode_e        mode,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   output logic [2*W-1:0]   prod
);
   localparam int PW = 2 * W;

   logic signed [PW-1:0] a_long, b_long, a_word, b_word;
   logic signed [PW-1:0] p_long, p_word;

   assign a_long = $signed({{W{a[W-1]}}, a});
   assign b_long = $signed({{W{b[W-1]}}, b});
   assign a_word = $signed({{(PW-HW){a[HW-1]}}, a[HW-1:0]});
   assign b_word = $signed({{(PW-HW){b[HW-1]}}, b[HW-1:0]});

   assign p_long = a_long * b_long;
   assign p_word = a_word * b_word;

   assign prod = (mode == MODE_WORD) ? p_word : p_long;

   always_comb begin
      AST_WORD_PROD_RANGE: assert ((mode != MODE_WORD) ||
         (p_word[PW-1:2*HW-1] == '0) || (p_word[PW-1:2*HW-1] == '1)); // R3
   end
endmodule

// File: rtl/mac_clip.sv
module mac_clip
   import mac_pkg::*;
#(
   parameter int W        = 32,
   parameter int LONG_SAT = 48
) (
   input  logic [2*W-1:0] acc,
   input  logic [2*W-1:0] prod,
   input  mac_mode_e      mode,
   input  logic           sat_en,
   output logic [2*W-1:0] nxt
);
   localparam int ONE_LO = LONG_SAT - W;
   localparam logic [W-1:0] LO_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] LO_MIN = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] FLAG   = {{(W-1){1'b0}}, 1'b1};

   logic [2*W-1:0] sum;
   logic [W-1:0]   s_hi, s_lo, long_hi;
   logic           neg, over_pos, over_neg;

   assign sum  = acc + prod;
   assign s_hi = sum[2*W-1:W];
   assign s_lo = sum[W-1:0];
   assign neg  = sum[2*W-1];

   for (genvar j = 0; j < W; j++) begin : g_hi_bit
      if (j >= ONE_LO) begin : g_fill
         assign long_hi[j] = neg;
      end else if (j == ONE_LO - 1) begin : g_edge
         assign long_hi[j] = neg & s_hi[j];
      end else begin : g_keep
         assign long_hi[j] = s_hi[j];
      end
   end

   assign over_pos = !neg && (sum[2*W-2:W-1] != '0);
   assign over_neg =  neg && (sum[2*W-2:W-1] != '1);

   always_comb begin
      nxt = sum;
      if (sat_en) begin
         if (mode == MODE_LONG) begin
            nxt = {long_hi, s_lo};
         end else if (over_pos) begin
            nxt = {FLAG, LO_MAX};
         end else if (over_neg) begin
            nxt = {FLAG, LO_MIN};
         end
      end
   end
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           ld_hi,
   input  logic           ld_lo,
   input  logic [W-1:0]   ld_data,
   input  logic           op_valid,
   input  logic [2*W-1:0] op_result,
   output logic [W-1:0]   q_hi,
   output logic [W-1:0]   q_lo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_hi <= '0;
         q_lo <= '0;
      end else if (clr) begin
         q_hi <= '0;
         q_lo <= '0;
      end else if (ld_hi || ld_lo) begin
         if (ld_hi) q_hi <= ld_data;
         if (ld_lo) q_lo <= ld_data;
      end else if (op_valid) begin
         q_hi <= op_result[2*W-1:W];
         q_lo <= op_result[W-1:0];
      end
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q_hi == '0 && q_lo == '0)); // R8
   AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ld_lo) |=> (q_lo == $past(ld_data))); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld_hi && !ld_lo && !op_valid) |=> ($stable(q_hi) && $stable(q_lo))); // R11
endmodule

// File: rtl/sat_mac.sv
module sat_mac
   import mac_pkg::*;
#(
   parameter int W        = 32,
   parameter int HW       = 16,
   parameter int LONG_SAT = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic         op_mode,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         sat_en,
   input  logic         clr,
   input  logic         ld_hi,
   input  logic         ld_lo,
   input  logic [W-1:0] ld_data,
   output logic [W-1:0] acc_hi,
   output logic [W-1:0] acc_lo
);
   localparam int ONE_LO = LONG_SAT - W;
   localparam logic [W-1:0] LO_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] LO_MIN = {1'b1, {(W-1){1'b0}}};

   initial begin
      AST_PARAM_OK: assert (HW > 0 && HW <= W && LONG_SAT > W + 1 && LONG_SAT < 2 * W); // R5
   end

   mac_mode_e      mode;
   logic [2*W-1:0] prod, nxt;

   assign mode = mac_mode_e'(op_mode);

   mac_prod #(.W(W), .HW(HW)) u_prod (
      .mode (mode),
      .a    (op_a),
      .b    (op_b),
      .prod (prod)
   );

   mac_clip #(.W(W), .LONG_SAT(LONG_SAT)) u_clip (
      .acc    ({acc_hi, acc_lo}),
      .prod   (prod),
      .mode   (mode),
      .sat_en (sat_en),
      .nxt    (nxt)
   );

   mac_acc_reg #(.W(W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .ld_hi     (ld_hi),
      .ld_lo     (ld_lo),
      .ld_data   (ld_data),
      .op_valid  (op_valid),
      .op_result (nxt),
      .q_hi      (acc_hi),
      .q_lo      (acc_lo)
   );

   AST_LONG_SAT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_mode && sat_en && !clr && !ld_hi && !ld_lo)
      |=> ((&acc_hi[W-1:ONE_LO]) || (acc_hi[W-1:ONE_LO-1] == '0))); // R5
   AST_WORD_SAT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_mode && sat_en && !clr && !ld_hi && !ld_lo)
      |=> ((acc_hi == {W{acc_lo[W-1]}}) ||
           (acc_hi == 1 && (acc_lo == LO_MAX || acc_lo == LO_MIN)))); // R6
   AST_LOAD_BLOCKS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ld_hi && !ld_lo) |=> $stable(acc_lo)); // R10
endmodule

// File: tb/sat_mac_tb.sv
module sat_mac_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_mode = 1'b0, sat_en = 1'b0;
   logic        clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
   logic [31:0] op_a = '0, op_b = '0, ld_data = '0;
   logic [31:0] acc_hi, acc_lo;

   int errors = 0;
   int checks = 0;
   logic [63:0] m_acc = '0;
   logic [63:0] exp_q[$];
   string       req_q[$];

   always #5 clk = ~clk;

   sat_mac u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
      .op_a(op_a), .op_b(op_b), .sat_en(sat_en), .clr(clr),
      .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_data(ld_data),
      .acc_hi(acc_hi), .acc_lo(acc_lo)
   );

   function automatic logic [63:0] model_op(logic [63:0] acc, logic mode,
         logic [31:0] a, logic [31:0] b, logic sat);
      longint pa, pb, s;
      logic [63:0] sum;
      logic [31:0] hi;
      if (mode) begin
         pa = longint'($signed(a[15:0]));
         pb = longint'($signed(b[15:0]));
      end else begin
         pa = longint'($signed(a));
         pb = longint'($signed(b));
      end
      sum = acc + 64'(pa * pb);
      if (!sat) return sum;
      if (!mode) begin
         hi = sum[63:32];
         if (sum[63]) hi = hi | 32'hFFFF0000;
         else         hi = hi & 32'h00007FFF;
         return {hi, sum[31:0]};
      end
      s = $signed(sum);
      if (s > 64'sd2147483647)  return {32'd1, 32'h7FFFFFFF};
      if (s < -64'sd2147483648) return {32'd1, 32'h80000000};
      return sum;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(string req, logic v, logic md, logic [31:0] a,
         logic [31:0] b, logic st, logic c, logic lh, logic ll, logic [31:0] d);
      @(negedge clk);
      op_valid = v; op_mode = md; op_a = a; op_b = b; sat_en = st;
      clr = c; ld_hi = lh; ld_lo = ll; ld_data = d;
      @(posedge clk);
      #1;
      if (c) m_acc = '0;
      else if (lh || ll) begin
         if (lh) m_acc[63:32] = d;
         if (ll) m_acc[31:0] = d;
      end else if (v) m_acc = model_op(m_acc, md, a, b, st);
      exp_q.push_back(m_acc);
      req_q.push_back(req);
      op_valid = 0; clr = 0; ld_hi = 0; ld_lo = 0;
   endtask

   task automatic load(string req, logic [31:0] h, logic [31:0] l);
      step(req, 0, 0, 0, 0, 0, 0, 1, 0, h);
      step(req, 0, 0, 0, 0, 0, 0, 0, 1, l);
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0) check(req_q.pop_front(), {acc_hi, acc_lo}, exp_q.pop_front());
      end
   end

   initial begin : watchdog
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 in reset", {acc_hi, acc_lo}, 64'h0);
      rst_n = 1'b1;
      step("R1 idle after reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      // R2 long products, mixed signs
      step("R2 neg*pos",  1, 0, 32'hFFFFFFFD, 32'd7, 0, 0, 0, 0, 0);
      step("R2 neg*neg",  1, 0, 32'h80000000, 32'h80000000, 0, 0, 0, 0, 0);
      step("R12 R2 pos*pos", 1, 0, 32'h00012345, 32'h00100000, 0, 0, 0, 0, 0);
      // R3 word mode ignores upper bits
      step("R8 clr", 0, 0, 0, 0, 0, 1, 0, 0, 0);
      step("R3 low halves", 1, 1, 32'hABCD0005, 32'h1234FFFE, 0, 0, 0, 0, 0);
      step("R3 upper junk", 1, 1, 32'hFFFF7FFF, 32'h00018000, 0, 0, 0, 0, 0);
      // R4 wraparound
      load("R9 load", 32'h7FFFFFFF, 32'hFFFFFFFF);
      step("R4 long wrap", 1, 0, 32'd1, 32'd1, 0, 0, 0, 0, 0);
      load("R9 load", 32'hFFFFFFFF, 32'hFFFFFFFF);
      step("R4 word wrap", 1, 1, 32'd1, 32'd1, 0, 0, 0, 0, 0);
      // R5 long saturation
      step("R8 clr", 0, 0, 0, 0, 0, 1, 0, 0, 0);
      step("R5 long sat pos", 1, 0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1, 0, 0, 0, 0);
      step("R8 clr", 0, 0, 0, 0, 0, 1, 0, 0, 0);
      step("R5 long sat neg", 1, 0, 32'h80000000, 32'h7FFFFFFF, 1, 0, 0, 0, 0);
      // R6 word saturation both directions
      load("R9 load", 32'h0, 32'h7FFFFFF0);
      step("R6 word sat high", 1, 1, 32'h00007FFF, 32'h00007FFF, 1, 0, 0, 0, 0);
      load("R9 load", 32'hFFFFFFFF, 32'h80000010);
      step("R6 word sat low", 1, 1, 32'h00007FFF, 32'h00008000, 1, 0, 0, 0, 0);
      // R7 in range
      step("R8 clr", 0, 0, 0, 0, 0, 1, 0, 0, 0);
      step("R7 word in range", 1, 1, 32'd100, 32'hFFFFFFFD, 1, 0, 0, 0, 0);
      // R8 clr beats op and load
      step("R8 clr over op", 1, 0, 32'd5, 32'd5, 0, 1, 1, 1, 32'h12345678);
      // R9 independent halves
      step("R9 lo only", 0, 0, 0, 0, 0, 0, 0, 1, 32'hCAFEF00D);
      step("R9 hi only", 0, 0, 0, 0, 0, 0, 1, 0, 32'h0BADBEEF);
      // R10 load discards op
      step("R10 ld_hi with op", 1, 0, 32'd9, 32'd9, 0, 0, 1, 0, 32'h00000042);
      step("R10 ld_lo with op", 1, 1, 32'd9, 32'd9, 1, 0, 0, 1, 32'h00000024);
      // R11 hold
      step("R11 idle", 0, 1, 32'd3, 32'd3, 1, 0, 0, 0, 0);
      step("R11 idle", 0, 0, 32'hFFFFFFFF, 32'd3, 0, 0, 0, 0, 0);
      @(negedge clk);
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule